// File: doc/BRIEF.md
# Miss Tracking Register File

This block keeps track of memory reads that missed in a SIMD core's first-level caches and are waiting for data. A fixed pool of entries holds one outstanding line request each. The entry records the line address, the memory space, whether the primary request was a write, and the list of warps waiting on it. A later read to the same line and space that finds an entry still waiting for its fill joins that entry's list and sends no new memory request. When the fill for an entry arrives, the waiting requests leave one at a time through a valid/ready return port toward writeback, in the order they joined.

Free entries sit in a FIFO free list. A new miss takes the head of that list, and a drained entry is appended at the tail. Fills for ordinary spaces arrive in any order. The entries they complete are queued in fill order on a return queue. Texture-space entries are instead kept in allocation order in a separate pipeline, and only the oldest one may return, once its fill has arrived. When both paths have work, the return queue wins. A high-water counter reports the largest number of entries that were ever held at once.

Top module: `mshr_file`

## Requirements
- R1: After reset the return port is not valid, `hw_o` is 0, and successive new entries are handed out as ids 0, 1, 2 and so on in ascending order.
- R2: A request that neither merges nor stalls gets the entry at the head of the free list, with `alloc_merged_o` = 0. Released entries join the tail of the free list in the order they were released.
- R3: A read to a line address and space that match an entry still awaiting its fill, whose primary request was a read, is merged: `alloc_merged_o` = 1 and `alloc_id_o` names that entry. An entry holds at most MAX_MERGE requests, and a matching read beyond that limit is stalled.
- R4: A write never merges into an existing entry, and no request merges into an entry whose primary request was a write. Each such request gets an entry of its own.
- R5: With no free entry and no mergeable match, `alloc_stall_o` is raised and nothing is recorded. A mergeable match is still accepted when the pool is full.
- R6: After the fill of a non-texture entry, its requests appear on the return port one per handshake, in the order they joined. Each shows the entry id, address, space, warp and write flag, and `ret_last_o` is 1 only on the final one.
- R7: Texture entries (space code 2'b10) return strictly in allocation order. A filled texture entry behind an unfilled one is not offered.
- R8: When a return-queue entry and a filled front texture entry are both pending, the return-queue entry is offered first.
- R9: An entry goes back to the free list in the cycle after the handshake of its last request. During that cycle it cannot yet be allocated.
- R10: A fill naming an entry that is not awaiting a fill has no effect.
- R11: `hw_o` never decreases and reaches the largest number of entries held at once.
- R12: While the return port is valid and not accepted, and no fill arrives, the offered request stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | 1 | Miss request present |
| alloc_addr_i | input | ADDR_W | Line address of the miss |
| alloc_space_i | input | 2 | Memory space code (2'b10 is texture) |
| alloc_warp_i | input | WARP_W | Issuing warp id |
| alloc_wr_i | input | 1 | Request is a write |
| alloc_stall_o | output | 1 | Request refused this cycle |
| alloc_merged_o | output | 1 | Request joined an existing entry |
| alloc_id_o | output | log2(NUM_ENTRIES) | Entry used by the request |
| fill_valid_i | input | 1 | Fill data arrived |
| fill_id_i | input | log2(NUM_ENTRIES) | Entry that the fill completes |
| ret_valid_o | output | 1 | A waiting request is released |
| ret_ready_i | input | 1 | Writeback side accepts the release |
| ret_id_o | output | log2(NUM_ENTRIES) | Entry of the released request |
| ret_addr_o | output | ADDR_W | Line address |
| ret_space_o | output | 2 | Memory space code |
| ret_warp_o | output | WARP_W | Warp to wake |
| ret_wr_o | output | 1 | Released request was a write |
| ret_last_o | output | 1 | Final request of the entry |
| hw_o | output | log2(NUM_ENTRIES+1) | Most entries held at once |

## Verification
The assertions check several properties on every cycle. A stall only ever answers a real request, and a merge never coincides with a stall. A freshly allocated entry is never the one being returned, an offered release holds still until it is taken, a drained entry is not offered again in the next cycle, and the high-water value rises monotonically within its bound. The bench scenarios are needed for the rest, because that depends on sequences: the free-list order and its reuse after release, the merge limit, keeping writes out of merges, texture ordering against out-of-order fills, return-queue priority, the one-cycle release gap, and ignored stray fills.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
  localparam int SPACE_W = 2;
  typedef logic [SPACE_W-1:0] space_t;
  localparam space_t SPACE_TEX = 2'b10;

  typedef enum logic [1:0] {
    ST_FREE  = 2'd0,
    ST_PEND  = 2'd1,
    ST_READY = 2'd2
  } ent_state_e;
endpackage

// File: rtl/mshr_id_fifo.sv
module mshr_id_fifo #(
  parameter int DEPTH    = 8,
  parameter int W        = 3,
  parameter bit INIT_SEQ = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] push_data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic [CNT_W-1:0] cnt;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign head_o  = mem[rd_ptr];
  assign empty_o = (cnt == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= INIT_SEQ ? W'(i) : '0;
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= INIT_SEQ ? CNT_W'(DEPTH) : '0;
    end else begin
      if (push_i) begin
        mem[wr_ptr] <= push_data_i;
        wr_ptr      <= nxt(wr_ptr);
      end
      if (pop_i) rd_ptr <= nxt(rd_ptr);
      cnt <= cnt + CNT_W'(push_i) - CNT_W'(pop_i);
    end
  end
endmodule

// File: rtl/mshr_match.sv
module mshr_match
  import mshr_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int ADDR_W      = 32,
  localparam int ID_W       = $clog2(NUM_ENTRIES)
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  space_t            space_i,
  input  logic              cand_i     [NUM_ENTRIES],
  input  logic [ADDR_W-1:0] ent_addr_i [NUM_ENTRIES],
  input  space_t            ent_space_i[NUM_ENTRIES],
  output logic              hit_o,
  output logic [ID_W-1:0]   id_o
);
  logic [NUM_ENTRIES-1:0] eq;

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
    assign eq[g] = cand_i[g] && (ent_addr_i[g] == addr_i) && (ent_space_i[g] == space_i);
  end

  always_comb begin
    hit_o = 1'b0;
    id_o  = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (eq[i]) begin
        hit_o = 1'b1;
        id_o  = ID_W'(i);
      end
    end
  end
endmodule

// File: rtl/mshr_file.sv
module mshr_file
  import mshr_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int MAX_MERGE   = 4,
  parameter int ADDR_W      = 32,
  parameter int WARP_W      = 5,
  localparam int ID_W       = $clog2(NUM_ENTRIES),
  localparam int CNT_W      = $clog2(NUM_ENTRIES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_valid_i,
  input  logic [ADDR_W-1:0] alloc_addr_i,
  input  logic [1:0]        alloc_space_i,
  input  logic [WARP_W-1:0] alloc_warp_i,
  input  logic              alloc_wr_i,
  output logic              alloc_stall_o,
  output logic              alloc_merged_o,
  output logic [ID_W-1:0]   alloc_id_o,
  input  logic              fill_valid_i,
  input  logic [ID_W-1:0]   fill_id_i,
  output logic              ret_valid_o,
  input  logic              ret_ready_i,
  output logic [ID_W-1:0]   ret_id_o,
  output logic [ADDR_W-1:0] ret_addr_o,
  output logic [1:0]        ret_space_o,
  output logic [WARP_W-1:0] ret_warp_o,
  output logic              ret_wr_o,
  output logic              ret_last_o,
  output logic [CNT_W-1:0]  hw_o
);
  localparam int SLOT_W = $clog2(MAX_MERGE + 1);
  localparam int SIDX_W = $clog2(MAX_MERGE);

  // entry storage
  ent_state_e        ent_state  [NUM_ENTRIES];
  logic [ADDR_W-1:0] ent_addr   [NUM_ENTRIES];
  space_t            ent_space  [NUM_ENTRIES];
  logic              ent_nomrg  [NUM_ENTRIES];
  logic [SLOT_W-1:0] ent_cnt    [NUM_ENTRIES];
  logic [SIDX_W-1:0] ent_rd     [NUM_ENTRIES];
  logic [WARP_W-1:0] slot_warp  [NUM_ENTRIES][MAX_MERGE];
  logic              slot_wr    [NUM_ENTRIES][MAX_MERGE];
  logic              cand       [NUM_ENTRIES];

  logic [ID_W-1:0]  free_head, rq_head, tx_head, m_id, sel;
  logic             free_empty, rq_empty, tx_empty, m_hit;
  logic             hit, slots_full, do_merge, do_new;
  logic             fill_ok, rq_push, tx_push, tex_ready, from_rq;
  logic             fire, done;
  logic             rel_q;
  logic [ID_W-1:0]  rel_id_q;
  logic [CNT_W-1:0] in_use_q, hw_q;

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cand
    assign cand[g] = (ent_state[g] == ST_PEND) && !ent_nomrg[g];
  end

  mshr_match #(.NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W)) u_match (
    .addr_i      (alloc_addr_i),
    .space_i     (alloc_space_i),
    .cand_i      (cand),
    .ent_addr_i  (ent_addr),
    .ent_space_i (ent_space),
    .hit_o       (m_hit),
    .id_o        (m_id)
  );

  // allocate decision
  assign hit        = m_hit && !alloc_wr_i;
  assign slots_full = (ent_cnt[m_id] == SLOT_W'(MAX_MERGE));
  assign do_merge   = alloc_valid_i && hit && !slots_full;
  assign do_new     = alloc_valid_i && !hit && !free_empty;

  assign alloc_stall_o  = alloc_valid_i && !do_merge && !do_new;
  assign alloc_merged_o = do_merge;
  assign alloc_id_o     = hit ? m_id : free_head;

  // fill
  assign fill_ok = fill_valid_i && (ent_state[fill_id_i] == ST_PEND);
  assign rq_push = fill_ok && (ent_space[fill_id_i] != SPACE_TEX);
  assign tx_push = do_new && (alloc_space_i == SPACE_TEX);

  // return select: queue before texture front
  assign tex_ready = !tx_empty && (ent_state[tx_head] == ST_READY);
  assign from_rq   = !rq_empty;
  assign sel       = from_rq ? rq_head : tx_head;

  assign ret_valid_o = from_rq || tex_ready;
  assign ret_id_o    = sel;
  assign ret_addr_o  = ent_addr[sel];
  assign ret_space_o = ent_space[sel];
  assign ret_warp_o  = slot_warp[sel][ent_rd[sel]];
  assign ret_wr_o    = slot_wr[sel][ent_rd[sel]];
  assign ret_last_o  = (SLOT_W'(ent_rd[sel]) + SLOT_W'(1)) == ent_cnt[sel];

  assign fire = ret_valid_o && ret_ready_i;
  assign done = fire && ret_last_o;

  mshr_id_fifo #(.DEPTH(NUM_ENTRIES), .W(ID_W), .INIT_SEQ(1'b1)) u_free (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (rel_q),
    .push_data_i (rel_id_q),
    .pop_i       (do_new),
    .head_o      (free_head),
    .empty_o     (free_empty)
  );

  mshr_id_fifo #(.DEPTH(NUM_ENTRIES), .W(ID_W), .INIT_SEQ(1'b0)) u_retq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (rq_push),
    .push_data_i (fill_id_i),
    .pop_i       (done && from_rq),
    .head_o      (rq_head),
    .empty_o     (rq_empty)
  );

  mshr_id_fifo #(.DEPTH(NUM_ENTRIES), .W(ID_W), .INIT_SEQ(1'b0)) u_texq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (tx_push),
    .push_data_i (free_head),
    .pop_i       (done && !from_rq),
    .head_o      (tx_head),
    .empty_o     (tx_empty)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        ent_state[i] <= ST_FREE;
        ent_addr[i]  <= '0;
        ent_space[i] <= '0;
        ent_nomrg[i] <= 1'b0;
        ent_cnt[i]   <= '0;
        ent_rd[i]    <= '0;
        for (int j = 0; j < MAX_MERGE; j++) begin
          slot_warp[i][j] <= '0;
          slot_wr[i][j]   <= 1'b0;
        end
      end
    end else begin
      if (do_new) begin
        ent_state[free_head]    <= ST_PEND;
        ent_addr[free_head]     <= alloc_addr_i;
        ent_space[free_head]    <= alloc_space_i;
        ent_nomrg[free_head]    <= alloc_wr_i;
        ent_cnt[free_head]      <= SLOT_W'(1);
        ent_rd[free_head]       <= '0;
        slot_warp[free_head][0] <= alloc_warp_i;
        slot_wr[free_head][0]   <= alloc_wr_i;
      end
      if (do_merge) begin
        slot_warp[m_id][ent_cnt[m_id][SIDX_W-1:0]] <= alloc_warp_i;
        slot_wr[m_id][ent_cnt[m_id][SIDX_W-1:0]]   <= 1'b0;
        ent_cnt[m_id] <= ent_cnt[m_id] + SLOT_W'(1);
      end
      if (fill_ok) ent_state[fill_id_i] <= ST_READY;
      if (fire) begin
        if (ret_last_o) begin
          ent_state[sel] <= ST_FREE;
          ent_rd[sel]    <= '0;
        end else begin
          ent_rd[sel] <= ent_rd[sel] + SIDX_W'(1);
        end
      end
    end
  end

  // release lands on the free list one cycle after the last handshake
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rel_q    <= 1'b0;
      rel_id_q <= '0;
      in_use_q <= '0;
      hw_q     <= '0;
    end else begin
      rel_q    <= done;
      rel_id_q <= sel;
      in_use_q <= in_use_q + CNT_W'(do_new) - CNT_W'(rel_q);
      if (in_use_q > hw_q) hw_q <= in_use_q;
    end
  end

  assign hw_o = hw_q;
endmodule

// File: rtl/mshr_file_chk.sv
module mshr_file_chk #(
  parameter int NUM_ENTRIES = 8,
  localparam int ID_W       = $clog2(NUM_ENTRIES),
  localparam int CNT_W      = $clog2(NUM_ENTRIES + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             alloc_valid_i,
  input logic             alloc_stall_o,
  input logic             alloc_merged_o,
  input logic [ID_W-1:0]  alloc_id_o,
  input logic             fill_valid_i,
  input logic             ret_valid_o,
  input logic             ret_ready_i,
  input logic [ID_W-1:0]  ret_id_o,
  input logic [4:0]       ret_warp_lo,
  input logic             ret_last_o,
  input logic [CNT_W-1:0] hw_o
);
  assert_stall_needs_req_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_stall_o |-> alloc_valid_i);

  assert_merge_not_stall_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_merged_o |-> !alloc_stall_o);

  assert_new_id_not_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_valid_i && !alloc_stall_o && !alloc_merged_o && ret_valid_o) |-> (alloc_id_o != ret_id_o));

  assert_ret_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_valid_o && !ret_ready_i && !fill_valid_i) |=>
      (ret_valid_o && $stable(ret_id_o) && $stable(ret_warp_lo)));

  assert_drained_gone_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_valid_o && ret_ready_i && ret_last_o) |=> !(ret_valid_o && (ret_id_o == $past(ret_id_o))));

  assert_hw_monotonic_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (hw_o >= $past(hw_o)));

  assert_hw_bound_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_o <= CNT_W'(NUM_ENTRIES));
endmodule

bind mshr_file mshr_file_chk #(.NUM_ENTRIES(NUM_ENTRIES)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .alloc_valid_i  (alloc_valid_i),
  .alloc_stall_o  (alloc_stall_o),
  .alloc_merged_o (alloc_merged_o),
  .alloc_id_o     (alloc_id_o),
  .fill_valid_i   (fill_valid_i),
  .ret_valid_o    (ret_valid_o),
  .ret_ready_i    (ret_ready_i),
  .ret_id_o       (ret_id_o),
  .ret_warp_lo    (5'(ret_warp_o)),
  .ret_last_o     (ret_last_o),
  .hw_o           (hw_o)
);

// File: tb/mshr_file_bench.sv
`timescale 1ns/1ps
module mshr_file_bench;
  localparam int N  = 8;
  localparam int AW = 32;
  localparam int WW = 5;
  localparam int IW = 3;
  localparam int CW = 4;
  localparam int NV = 14;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          alloc_valid_i = 1'b0;
  logic [AW-1:0] alloc_addr_i = '0;
  logic [1:0]    alloc_space_i = '0;
  logic [WW-1:0] alloc_warp_i = '0;
  logic          alloc_wr_i = 1'b0;
  logic          alloc_stall_o, alloc_merged_o;
  logic [IW-1:0] alloc_id_o;
  logic          fill_valid_i = 1'b0;
  logic [IW-1:0] fill_id_i = '0;
  logic          ret_valid_o;
  logic          ret_ready_i = 1'b0;
  logic [IW-1:0] ret_id_o;
  logic [AW-1:0] ret_addr_o;
  logic [1:0]    ret_space_o;
  logic [WW-1:0] ret_warp_o;
  logic          ret_wr_o, ret_last_o;
  logic [CW-1:0] hw_o;

  always #2.5 clk_i = ~clk_i;

  mshr_file u_mshr_file (.*);

  int  n_chk = 0;
  int  n_fail = 0;
  bit  finished = 1'b0;

  // {addr, space, warp, wr, exp_stall, exp_merged, exp_id}
  localparam logic [44:0] VEC [NV] = '{
    {32'h100, 2'd0, 5'd1,  1'b0, 1'b0, 1'b0, 3'd0},  // R1 first id 0
    {32'h100, 2'd0, 5'd2,  1'b0, 1'b0, 1'b1, 3'd0},  // R3 merge
    {32'h100, 2'd0, 5'd3,  1'b0, 1'b0, 1'b1, 3'd0},  // R3
    {32'h100, 2'd0, 5'd4,  1'b0, 1'b0, 1'b1, 3'd0},  // R3 entry full
    {32'h100, 2'd0, 5'd5,  1'b0, 1'b1, 1'b0, 3'd0},  // R3 over limit
    {32'h100, 2'd1, 5'd6,  1'b0, 1'b0, 1'b0, 3'd1},  // R2 other space
    {32'h200, 2'd0, 5'd7,  1'b1, 1'b0, 1'b0, 3'd2},  // R4 write
    {32'h200, 2'd0, 5'd8,  1'b0, 1'b0, 1'b0, 3'd3},  // R4 no merge into write
    {32'h300, 2'd2, 5'd9,  1'b0, 1'b0, 1'b0, 3'd4},  // texture
    {32'h400, 2'd2, 5'd10, 1'b0, 1'b0, 1'b0, 3'd5},  // texture
    {32'h500, 2'd0, 5'd11, 1'b0, 1'b0, 1'b0, 3'd6},
    {32'h600, 2'd0, 5'd12, 1'b0, 1'b0, 1'b0, 3'd7},
    {32'h700, 2'd0, 5'd13, 1'b0, 1'b1, 1'b0, 3'd0},  // R5 pool full
    {32'h500, 2'd0, 5'd14, 1'b0, 1'b0, 1'b1, 3'd6}   // R5 merge when full
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input longint unsigned act, input longint unsigned exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_alloc(input logic [AW-1:0] a, input logic [1:0] sp, input logic [WW-1:0] w,
                          input logic wr, output logic st, output logic mg, output logic [IW-1:0] id);
    @(negedge clk_i);
    alloc_valid_i = 1'b1; alloc_addr_i = a; alloc_space_i = sp; alloc_warp_i = w; alloc_wr_i = wr;
    #1;
    st = alloc_stall_o; mg = alloc_merged_o; id = alloc_id_o;
    @(posedge clk_i);
    #1 alloc_valid_i = 1'b0;
  endtask

  task automatic do_fill(input logic [IW-1:0] id);
    @(negedge clk_i);
    fill_valid_i = 1'b1; fill_id_i = id;
    @(posedge clk_i);
    #1 fill_valid_i = 1'b0;
  endtask

  task automatic take(input string req, input logic [IW-1:0] id, input logic [15:0] a,
                      input logic [1:0] sp, input logic [WW-1:0] w, input logic wr, input logic last);
    logic [28:0] act, exp;
    @(negedge clk_i);
    #1;
    act = {ret_valid_o, ret_id_o, ret_addr_o[15:0], ret_space_o, ret_warp_o, ret_wr_o, ret_last_o};
    exp = {1'b1, id, a, sp, w, wr, last};
    chk(act == exp, req, "return {valid,id,addr,space,warp,wr,last}", 64'(act), 64'(exp));
    ret_ready_i = 1'b1;
    @(posedge clk_i);
    #1 ret_ready_i = 1'b0;
  endtask

  task automatic expect_idle(input string req, input string what);
    @(negedge clk_i);
    #1 chk(!ret_valid_o, req, what, 64'(ret_valid_o), 64'd0);
  endtask

  initial begin
    logic st, mg;
    logic [IW-1:0] id;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    chk(!ret_valid_o && hw_o == '0 && !alloc_stall_o, "R1", "reset state",
        64'({ret_valid_o, hw_o, alloc_stall_o}), 64'd0);

    for (int i = 0; i < NV; i++) begin
      do_alloc(VEC[i][44:13], VEC[i][12:11], VEC[i][10:6], VEC[i][5], st, mg, id);
      if (VEC[i][4])
        chk(st == 1'b1 && mg == 1'b0, "R2 R3 R4 R5", $sformatf("row %0d stall", i),
            64'({st, mg}), 64'b10);
      else
        chk(st == 1'b0 && mg == VEC[i][3] && id == VEC[i][2:0], "R2 R3 R4 R5",
            $sformatf("row %0d {stall,merged,id}", i), 64'({st, mg, id}),
            64'({1'b0, VEC[i][3], VEC[i][2:0]}));
    end

    @(negedge clk_i);
    #1 chk(hw_o == CW'(8), "R11", "high-water after filling pool", 64'(hw_o), 64'd8);
    expect_idle("R6", "no return before any fill");

    // R7: second texture entry filled first stays hidden
    do_fill(3'd5);
    expect_idle("R7", "texture entry behind unfilled front");
    do_fill(3'd4);
    do_fill(3'd1);
    // R12: held while not accepted
    repeat (2) @(negedge clk_i);
    #1 chk(ret_valid_o && ret_id_o == 3'd1 && ret_warp_o == 5'd6, "R12", "held offer {valid,id,warp}",
           64'({ret_valid_o, ret_id_o, ret_warp_o}), 64'({1'b1, 3'd1, 5'd6}));
    take("R8", 3'd1, 16'h100, 2'd1, 5'd6, 1'b0, 1'b1);   // queue over texture

    // R9: released entry not available in the following cycle
    do_alloc(32'h800, 2'd0, 5'd15, 1'b0, st, mg, id);
    chk(st == 1'b1, "R9", "alloc in release cycle stalls", 64'(st), 64'd1);
    do_alloc(32'h800, 2'd0, 5'd15, 1'b0, st, mg, id);
    chk(!st && !mg && id == 3'd1, "R9", "released entry reused {stall,merged,id}",
        64'({st, mg, id}), 64'({2'b00, 3'd1}));

    take("R7", 3'd4, 16'h300, 2'd2, 5'd9, 1'b0, 1'b1);
    take("R7", 3'd5, 16'h400, 2'd2, 5'd10, 1'b0, 1'b1);

    // R10: fill to a free entry ignored
    repeat (2) @(negedge clk_i);
    do_fill(3'd4);
    expect_idle("R10", "fill to free entry");

    // R6: merged chain in join order, last on the final one
    do_fill(3'd0);
    take("R6", 3'd0, 16'h100, 2'd0, 5'd1, 1'b0, 1'b0);
    take("R6", 3'd0, 16'h100, 2'd0, 5'd2, 1'b0, 1'b0);
    take("R6", 3'd0, 16'h100, 2'd0, 5'd3, 1'b0, 1'b0);
    take("R6", 3'd0, 16'h100, 2'd0, 5'd4, 1'b0, 1'b1);
    do_fill(3'd2);
    take("R4", 3'd2, 16'h200, 2'd0, 5'd7, 1'b1, 1'b1);
    do_fill(3'd3);
    take("R4", 3'd3, 16'h200, 2'd0, 5'd8, 1'b0, 1'b1);

    // R2: free list tail order 4,5,0,2,3
    @(negedge clk_i);
    do_alloc(32'h900, 2'd0, 5'd16, 1'b0, st, mg, id);
    chk(!st && !mg && id == 3'd4, "R2", "next id from free-list head", 64'(id), 64'd4);
    do_alloc(32'hA00, 2'd3, 5'd17, 1'b0, st, mg, id);
    chk(!st && !mg && id == 3'd5, "R2", "following id", 64'(id), 64'd5);
    @(negedge clk_i);
    #1 chk(hw_o == CW'(8), "R11", "high-water kept after drain", 64'(hw_o), 64'd8);

    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule